// File: doc/BRIEF.md
# DRAM Bank Row-State Tracker

This block sits beside the command path of a memory controller. It keeps a record, for each bank of the device, of whether a row is open and which row that is. Every command the controller issues is presented on a strobe together with its type, bank, row and column fields. The tracker judges the command against the recorded bank state and updates that state only when the command is allowed.

Reads may ask for automatic closing of the bank. The column field carries that request on one bit. Such a read leaves the bank in a closing state for the duration of the burst. The bank then closes by itself, with no precharge command on the bus. The verdict for each command appears one clock after it is sampled. That verdict carries a legal flag, a row-hit flag and an echo of the read column. The per-bank open, closing and row state is visible at all times.

Top module: `bank_row_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, every bank becomes closed and not closing, and `rsp_valid`, `rsp_legal`, `rsp_hit` and `rsp_col` become 0.
- R2: An activate (`cmd_type` 2) to a bank that is neither open nor closing is legal. After that edge the bank reads open and its `bank_row` slice holds `cmd_row`.
- R3: An activate to a bank that already has an open row is illegal, and the bank keeps its row.
- R4: A read (`cmd_type` 3) to an open, non-closing bank is legal. A read to a closed bank is illegal. No illegal command changes any bank state.
- R5: `rsp_hit` is 1 exactly when the command was a legal read and its `cmd_row` equalled the bank's tracked row.
- R6: A precharge (`cmd_type` 4) to an open bank is legal and closes it. A precharge to a closed bank is legal and changes nothing.
- R7: A legal read with `cmd_col[AP_BIT]` set (bit 10 by default) puts the bank into the closing state for BURST_LEN/2 cycles, and then the bank closes. Activate, read and precharge commands sampled on the BURST_LEN/2 edges after the read are illegal and have no effect.
- R8: Deselect (`cmd_type` 0) and no-operation (`cmd_type` 1) are legal and change no bank state, while a countdown in progress in any bank carries on. Type codes 5 to 7 are illegal and have no effect.
- R9: With `cmd_valid` low, the response after that edge has `rsp_valid` at 0 and the bank state is unchanged, apart from any countdown in progress.
- R10: The response to a command sampled at an edge is visible right after that edge. `rsp_col` equals `cmd_col` for a legal read and is 0 otherwise.
- R11: A command changes the state of only the bank that `cmd_bank` selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_type | input | 3 | 0 deselect, 1 no-op, 2 activate, 3 read, 4 precharge |
| cmd_bank | input | $clog2(NUM_BANKS) | Bank selector |
| cmd_row | input | ROW_W | Row address |
| cmd_col | input | COL_W | Column address; bit AP_BIT requests auto-close on reads |
| rsp_valid | output | 1 | A command was sampled on the previous edge |
| rsp_legal | output | 1 | That command was legal |
| rsp_hit | output | 1 | That command was a legal read to the tracked row |
| rsp_col | output | COL_W | Column of a legal read, else 0 |
| bank_open | output | NUM_BANKS | Per-bank row-open flag |
| bank_closing | output | NUM_BANKS | Per-bank auto-close countdown in progress |
| bank_row | output | NUM_BANKS*ROW_W | Tracked row per bank, bank 0 in the low slice |

## Verification
The hardest case to reach is a command that lands on a bank at an exact offset inside its auto-close window. The window is only reached through a precise order of steps, and its edges are one cycle apart. The stimulus therefore drives each bank through this order: drain, precharge, activate, then a read with the auto-close bit set. It then spends a swept number of cycles precharging a neighbouring bank, from zero up to the full window length. Finally it issues every type code, with the strobe on and off and with the row matching and not matching. Commands therefore fall both just inside and just past the window's end, while other banks are being opened and closed at the same time.

// File: rtl/brt_pkg.sv
package brt_pkg;

    typedef enum logic [2:0] {
        CMD_DES = 3'd0,
        CMD_NOP = 3'd1,
        CMD_ACT = 3'd2,
        CMD_RD  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef struct packed {
        logic idle;
        logic act;
        logic rd;
        logic pre;
        logic bad;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(logic [2:0] code);
        cmd_dec_t d;
        d = '0;
        case (code)
            CMD_DES, CMD_NOP: d.idle = 1'b1;
            CMD_ACT:          d.act  = 1'b1;
            CMD_RD:           d.rd   = 1'b1;
            CMD_PRE:          d.pre  = 1'b1;
            default:          d.bad  = 1'b1;
        endcase
        return d;
    endfunction

    function automatic logic op_allowed(cmd_dec_t d, logic is_open, logic is_closing);
        if (d.idle)
            return 1'b1;
        if (d.bad || is_closing)
            return 1'b0;
        if (d.act)
            return !is_open;
        if (d.rd)
            return is_open;
        return 1'b1;
    endfunction

endpackage

// File: rtl/brt_cmd_check.sv
module brt_cmd_check
    import brt_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = 3,
    parameter int ROW_W     = 14
) (
    input  logic                       cmd_valid,
    input  logic [2:0]                 cmd_type,
    input  logic [BANK_W-1:0]          cmd_bank,
    input  logic [ROW_W-1:0]           cmd_row,
    input  logic                       cmd_ap,
    input  logic [NUM_BANKS-1:0]       open_vec,
    input  logic [NUM_BANKS-1:0]       closing_vec,
    input  logic [NUM_BANKS*ROW_W-1:0] row_flat,
    output logic                       legal,
    output logic                       hit,
    output logic                       is_rd,
    output logic [NUM_BANKS-1:0]       act_vec,
    output logic [NUM_BANKS-1:0]       pre_vec,
    output logic [NUM_BANKS-1:0]       rdap_vec
);

    cmd_dec_t          dec;
    logic              sel_open;
    logic              sel_closing;
    logic [ROW_W-1:0]  sel_row;
    logic              apply;

    always_comb begin
        dec         = decode_cmd(cmd_type);
        sel_open    = open_vec[cmd_bank];
        sel_closing = closing_vec[cmd_bank];
        sel_row     = row_flat[int'(cmd_bank)*ROW_W +: ROW_W];
        legal       = op_allowed(dec, sel_open, sel_closing);
        is_rd       = dec.rd;
        hit         = legal && dec.rd && (cmd_row == sel_row);
        apply       = cmd_valid && legal;
    end

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
        logic match;
        assign match       = (cmd_bank == BANK_W'(i));
        assign act_vec[i]  = apply && match && dec.act;
        assign pre_vec[i]  = apply && match && dec.pre;
        assign rdap_vec[i] = apply && match && dec.rd && cmd_ap;
    end

endmodule

// File: rtl/brt_bank_slot.sv
module brt_bank_slot #(
    parameter int ROW_W      = 14,
    parameter int BURST_CLKS = 4,
    parameter int CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             do_act,
    input  logic             do_pre,
    input  logic             do_rdap,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic             is_closing,
    output logic [ROW_W-1:0] row_q
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open <= 1'b0;
            cnt     <= '0;
            row_q   <= '0;
        end else if (cnt != '0) begin
            if (cnt == CNT_W'(1)) begin
                cnt     <= '0;
                is_open <= 1'b0;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end else if (do_act) begin
            is_open <= 1'b1;
            row_q   <= row_in;
        end else if (do_pre) begin
            is_open <= 1'b0;
        end else if (do_rdap) begin
            cnt <= CNT_W'(BURST_CLKS);
        end
    end

    assign is_closing = (cnt != '0);

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker #(
    parameter  int NUM_BANKS = 8,
    parameter  int ROW_W     = 14,
    parameter  int COL_W     = 12,
    parameter  int AP_BIT    = 10,
    parameter  int BURST_LEN = 8,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_valid,
    input  logic [2:0]                 cmd_type,
    input  logic [BANK_W-1:0]          cmd_bank,
    input  logic [ROW_W-1:0]           cmd_row,
    input  logic [COL_W-1:0]           cmd_col,
    output logic                       rsp_valid,
    output logic                       rsp_legal,
    output logic                       rsp_hit,
    output logic [COL_W-1:0]           rsp_col,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS-1:0]       bank_closing,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row
);

    localparam int BURST_CLKS = BURST_LEN / 2;
    localparam int CNT_W      = $clog2(BURST_CLKS + 1);

    logic                 legal;
    logic                 hit;
    logic                 is_rd;
    logic [NUM_BANKS-1:0] act_vec;
    logic [NUM_BANKS-1:0] pre_vec;
    logic [NUM_BANKS-1:0] rdap_vec;

    brt_cmd_check #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .ROW_W     (ROW_W)
    ) u_check (
        .cmd_valid   (cmd_valid),
        .cmd_type    (cmd_type),
        .cmd_bank    (cmd_bank),
        .cmd_row     (cmd_row),
        .cmd_ap      (cmd_col[AP_BIT]),
        .open_vec    (bank_open),
        .closing_vec (bank_closing),
        .row_flat    (bank_row),
        .legal       (legal),
        .hit         (hit),
        .is_rd       (is_rd),
        .act_vec     (act_vec),
        .pre_vec     (pre_vec),
        .rdap_vec    (rdap_vec)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        brt_bank_slot #(
            .ROW_W      (ROW_W),
            .BURST_CLKS (BURST_CLKS),
            .CNT_W      (CNT_W)
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .do_act     (act_vec[b]),
            .do_pre     (pre_vec[b]),
            .do_rdap    (rdap_vec[b]),
            .row_in     (cmd_row),
            .is_open    (bank_open[b]),
            .is_closing (bank_closing[b]),
            .row_q      (bank_row[b*ROW_W +: ROW_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_legal <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_col   <= '0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_legal <= cmd_valid && legal;
            rsp_hit   <= cmd_valid && hit;
            rsp_col   <= (cmd_valid && legal && is_rd) ? cmd_col : '0;
        end
    end

endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
    parameter  int NUM_BANKS = 8,
    parameter  int ROW_W     = 14,
    parameter  int COL_W     = 12,
    parameter  int AP_BIT    = 10,
    parameter  int BURST_LEN = 8,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cmd_valid,
    input logic [2:0]                 cmd_type,
    input logic [BANK_W-1:0]          cmd_bank,
    input logic [ROW_W-1:0]           cmd_row,
    input logic [COL_W-1:0]           cmd_col,
    input logic                       rsp_valid,
    input logic                       rsp_legal,
    input logic                       rsp_hit,
    input logic [COL_W-1:0]           rsp_col,
    input logic [NUM_BANKS-1:0]       bank_open,
    input logic [NUM_BANKS-1:0]       bank_closing,
    input logic [NUM_BANKS*ROW_W-1:0] bank_row
);

    p_rst_closed_r1: assert property (@(posedge clk)
        rst |=> (bank_open == '0 && bank_closing == '0 && !rsp_valid));

    p_act_opens_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_type == 3'd2 && !bank_open[cmd_bank]
        |=> rsp_legal && bank_open[$past(cmd_bank)]
            && bank_row[int'($past(cmd_bank))*ROW_W +: ROW_W] == $past(cmd_row));

    p_act_open_bad_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_type == 3'd2 && bank_open[cmd_bank] |=> !rsp_legal);

    p_rd_closed_bad_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_type == 3'd3 && !bank_open[cmd_bank] |=> !rsp_legal && !rsp_hit);

    p_hit_legal_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid && rsp_legal);

    p_pre_closes_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_type == 3'd4 && !bank_closing[cmd_bank]
        |=> rsp_legal && !bank_open[$past(cmd_bank)]);

    p_closing_bad_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_type >= 3'd2 && bank_closing[cmd_bank] |=> !rsp_legal);

    p_closing_subset_r7: assert property (@(posedge clk) disable iff (rst)
        (bank_closing & ~bank_open) == '0);

    p_idle_stable_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_type <= 3'd1 && bank_closing == '0
        |=> rsp_legal && $stable(bank_open) && $stable(bank_row));

    p_novalid_r9: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_valid && !rsp_legal);

    p_col_echo_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_type == 3'd3 && bank_open[cmd_bank] && !bank_closing[cmd_bank]
        |=> rsp_legal && rsp_col == $past(cmd_col));

    p_col_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !rsp_legal |-> rsp_col == '0);

    p_ap_enters_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_type == 3'd3 && cmd_col[AP_BIT] && bank_open[cmd_bank]
        && !bank_closing[cmd_bank] |=> bank_closing[$past(cmd_bank)]);

endmodule

bind bank_row_tracker brt_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .AP_BIT    (AP_BIT),
    .BURST_LEN (BURST_LEN)
) u_chk (.*);

// File: tb/sim_bank_row_tracker.sv
`timescale 1ns/1ps
module sim_bank_row_tracker;

    localparam int NB = 8;
    localparam int RW = 14;
    localparam int CW = 12;
    localparam int AP = 10;
    localparam int BL = 8;
    localparam int BC = BL / 2;

    logic           clk = 1'b0;
    logic           rst;
    logic           cmd_valid;
    logic [2:0]     cmd_type;
    logic [2:0]     cmd_bank;
    logic [RW-1:0]  cmd_row;
    logic [CW-1:0]  cmd_col;
    logic           rsp_valid, rsp_legal, rsp_hit;
    logic [CW-1:0]  rsp_col;
    logic [NB-1:0]  bank_open, bank_closing;
    logic [NB*RW-1:0] bank_row;

    int total = 0;
    int bad   = 0;

    logic          m_open [NB];
    logic [RW-1:0] m_row  [NB];
    int            m_cnt  [NB];

    always #2 clk = ~clk;

    bank_row_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .AP_BIT(AP), .BURST_LEN(BL)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .rsp_valid(rsp_valid), .rsp_legal(rsp_legal), .rsp_hit(rsp_hit), .rsp_col(rsp_col),
        .bank_open(bank_open), .bank_closing(bank_closing), .bank_row(bank_row)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NB; i++) begin
            m_open[i] = 1'b0;
            m_row[i]  = '0;
            m_cnt[i]  = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 bank_open", 32'(bank_open), 0);
        chk("R1 bank_closing", 32'(bank_closing), 0);
        chk("R1 rsp_col", 32'(rsp_col), 0);
        rst = 1'b0;
    endtask

    task automatic issue(input logic v, input logic [2:0] t, input int b,
                         input logic [RW-1:0] r, input logic [CW-1:0] c);
        logic so, sc, leg, e_leg, e_hit;
        logic [CW-1:0] e_col;
        string tag;
        @(negedge clk);
        cmd_valid = v;
        cmd_type  = t;
        cmd_bank  = 3'(b);
        cmd_row   = r;
        cmd_col   = c;
        so = m_open[b];
        sc = (m_cnt[b] != 0);
        if (t <= 3'd1)      leg = 1'b1;
        else if (t >= 3'd5) leg = 1'b0;
        else if (sc)        leg = 1'b0;
        else if (t == 3'd2) leg = !so;
        else if (t == 3'd3) leg = so;
        else                leg = 1'b1;
        e_leg = v && leg;
        e_hit = e_leg && (t == 3'd3) && (r == m_row[b]);
        e_col = (e_leg && t == 3'd3) ? c : '0;
        if (!v)                    tag = "R9";
        else if (t <= 3'd1)        tag = "R8";
        else if (t >= 3'd5)        tag = "R8";
        else if (sc)               tag = "R7";
        else if (t == 3'd2)        tag = so ? "R3" : "R2";
        else if (t == 3'd3)        tag = "R4";
        else                       tag = "R6";
        for (int i = 0; i < NB; i++) begin
            if (m_cnt[i] == 1) begin
                m_cnt[i]  = 0;
                m_open[i] = 1'b0;
            end else if (m_cnt[i] > 1) begin
                m_cnt[i] = m_cnt[i] - 1;
            end
        end
        if (e_leg) begin
            if (t == 3'd2) begin
                m_open[b] = 1'b1;
                m_row[b]  = r;
            end else if (t == 3'd4) begin
                m_open[b] = 1'b0;
            end else if (t == 3'd3 && c[AP]) begin
                m_cnt[b] = BC;
            end
        end
        @(posedge clk);
        #1;
        chk("R9 rsp_valid", 32'(rsp_valid), 32'(v));
        chk({tag, " rsp_legal"}, 32'(rsp_legal), 32'(e_leg));
        chk("R5 rsp_hit", 32'(rsp_hit), 32'(e_hit));
        chk("R10 rsp_col", 32'(rsp_col), 32'(e_col));
        for (int i = 0; i < NB; i++) begin
            if (i == b) chk({tag, " bank_open"}, 32'(bank_open[i]), 32'(m_open[i]));
            else        chk("R11 bank_open", 32'(bank_open[i]), 32'(m_open[i]));
            chk("R7 bank_closing", 32'(bank_closing[i]), 32'(m_cnt[i] != 0));
            if (m_open[i])
                chk("R2 bank_row", 32'(bank_row[i*RW +: RW]), 32'(m_row[i]));
        end
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cmd_valid = 1'b0;
        cmd_type = 3'd0;
        cmd_bank = 3'd0;
        cmd_row = '0;
        cmd_col = '0;
        model_reset();
        do_reset();

        for (int b = 0; b < NB; b++) begin
            for (int st = 0; st < 3; st++) begin
                for (int d = 0; d <= ((st == 2) ? BC : 0); d++) begin
                    for (int code = 0; code < 8; code++) begin
                        for (int v = 0; v < 2; v++) begin
                            for (int m = 0; m < 2; m++) begin
                                int nb;
                                logic [RW-1:0] rowv;
                                logic [CW-1:0] colv;
                                nb   = b ^ 1;
                                rowv = RW'(b * 131 + code * 17 + st * 5 + d + 1);
                                colv = CW'((code[0] << AP) | (code * 8 + d));
                                repeat (BC + 1) issue(1'b1, 3'd1, nb, '0, '0);
                                issue(1'b1, 3'd2, (b + 2) % NB, rowv ^ RW'(7), '0);
                                issue(1'b1, 3'd4, b, '0, '0);
                                if (st >= 1) issue(1'b1, 3'd2, b, rowv, '0);
                                if (st == 2) issue(1'b1, 3'd3, b, rowv, CW'((1 << AP) | 5));
                                for (int k = 0; k < d; k++) issue(1'b1, 3'd4, nb, '0, '0);
                                issue(v[0], 3'(code), b, m[0] ? rowv : (rowv ^ RW'(1)), colv);
                            end
                        end
                    end
                end
            end
        end

        issue(1'b1, 3'd2, 3, RW'(99), '0);
        issue(1'b1, 3'd2, 5, RW'(77), '0);
        do_reset();
        issue(1'b1, 3'd3, 3, RW'(99), '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule